// File: doc/BRIEF.md
# Multichannel SPI Master Controller

This block is a register-programmed SPI master that serves several slaves through separate chip-select lines. Each channel has its own configuration word, holding word length, chip-select polarity, clock polarity, clock phase, transfer mode and FIFO assignment. Each channel also has its own enable bit, transmit register and receive register. One shared shifter serves the lowest-numbered enabled channel that has work. Software switches between slaves by disabling one channel and enabling another.

A transfer never starts by itself. It begins only after the host writes a channel's transmit register. In receive-only mode that single write arms the channel. The channel then keeps receiving a word whenever it has room for one, until it is disabled. Per-channel transmit-empty and receive-full flags are cleared by writing 1. A small transmit FIFO and receive FIFO can be handed to one channel at a time, for either direction or both. A request to give them to a second channel is refused and flagged. The serial clock runs at the system clock divided by 2^(HALF_LOG+1).

Top module: `spi_mc_master`

## Requirements
- R1: The word length is taken from configuration bits [11:7] as field+1. Field values below 3 give 4 bits. Each word is sent MSB first on `mosi_o` with exactly that many serial clock cycles, and the received bits are right-aligned in the receive register.
- R2: Configuration bit 1 sets the idle level of `sclk_o`: 0 idles low and 1 idles high.
- R3: When configuration bit 0 is 0, `miso_i` is sampled and `mosi_o` is stable on odd clock edges (1st, 3rd, …). When it is 1, both happen on even edges.
- R4: When configuration bit 6 is 0, the channel's chip select is high while its word is on the wire and low otherwise. When the bit is 1, these levels are inverted. At most one chip select is active at a time.
- R5: Control register bit 0 enables a channel. A disabled channel never starts a word, and its written transmit data stays pending until the channel is enabled.
- R6: In the status register, bit 2c is transmit-empty and bit 2c+1 is receive-full for channel c. Both are 0 after reset. Transmit-empty is set when the word is loaded into the shifter, and receive-full is set when a word completes. Writing 1 to a bit clears only that bit.
- R7: Configuration bits [13:12] select the mode. 00 is transmit-and-receive and 10 is transmit-only, which never sets receive-full. 01 is receive-only: `mosi_o` stays low, and one transmit-register write arms repeated reception, with one word each time receive-full is clear.
- R8: With no transmit-register write, an enabled channel produces no serial clock and no chip-select activity.
- R9: Configuration bit 27 gives the FIFO to a channel for writes, and bit 28 gives it for reads. If another channel already owns the FIFO, both bits are dropped from the write and status bit 2·NCH (error, write-1-to-clear) is set.
- R10: With the FIFO owned for writes, up to FD transmit words queue and go out in order. With it owned for reads, completed words are returned in order, one per read of the receive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops receive FIFO) |
| reg_addr | input | $clog2(4*NCH+1) | Register address: channel c at 4c+{0 conf,1 ctrl,2 tx,3 rx}; status at 4·NCH |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NCH | Per-channel chip selects |

## Verification
A wrong edge counter or phase latch shows up within a single word as a clock-cycle count other than the word length, or as a shifted and corrupted value in the receive register. A stuck enable, arm or pending bit shows up at the ports as a chip select that toggles with no transmit write, or that stays idle after one. This is visible within about a hundred cycles. A corrupted FIFO owner or pointer shows up as words leaving or returning out of order, or as configuration bits that read back where a refusal was expected.

// File: rtl/spi_mc_master.sv
module spi_mc_master #(
  parameter int NCH      = 2,
  parameter int HALF_LOG = 1,
  parameter int FD       = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic                         reg_re,
  input  logic [$clog2(4*NCH+1)-1:0]   reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  output logic                         sclk_o,
  output logic                         mosi_o,
  input  logic                         miso_i,
  output logic [NCH-1:0]               cs_o
);
  localparam int AW   = $clog2(4*NCH+1);
  localparam int CW   = $clog2(NCH);
  localparam int FAW  = $clog2(FD);
  localparam int HALF = 1 << HALF_LOG;
  localparam logic [AW-1:0] ST_ADDR = AW'(4*NCH);

  function automatic logic [5:0] wl_of(input logic [31:0] c);
    return (c[11:7] < 5'd3) ? 6'd4 : {1'b0, c[11:7]} + 6'd1;
  endfunction

  logic [31:0]    conf   [NCH];
  logic [31:0]    txbuf  [NCH];
  logic [31:0]    rxbuf  [NCH];
  logic [NCH-1:0] en, txfull, armed, txe, rxf, own, ready, rxonly, txonly;
  logic           err;

  logic           own_any, fw, fr;
  logic [CW-1:0]  own_idx;
  logic [AW-3:0]  a_ch;
  logic [1:0]     a_reg;
  logic           a_chan;

  assign a_ch   = reg_addr[AW-1:2];
  assign a_reg  = reg_addr[1:0];
  assign a_chan = reg_addr < ST_ADDR;

  logic [31:0] tfifo [FD];
  logic [31:0] rfifo [FD];
  logic [FAW-1:0] tf_rp, tf_wp, rf_rp, rf_wp;
  logic [FAW:0]   tf_cnt, rf_cnt;

  logic           busy, cpha_q, cpol_q, sclk_t, start, tick, done;
  logic [CW-1:0]  ch, cur_ch, sel;
  logic [1:0]     mode_q;
  logic [5:0]     nbits;
  logic [6:0]     ecnt, kn;
  logic [HALF_LOG:0] dcnt;
  logic [31:0]    shreg, rxsh, txword;
  logic           smp, shf;

  always_comb begin
    own_any = 1'b0;
    own_idx = '0;
    for (int c = 0; c < NCH; c++) begin
      own[c]    = conf[c][27] | conf[c][28];
      rxonly[c] = conf[c][13:12] == 2'b01;
      txonly[c] = conf[c][13:12] == 2'b10;
      if (own[c]) begin
        own_any = 1'b1;
        own_idx = CW'(c);
      end
    end
  end
  assign fw = own_any && conf[own_idx][27];
  assign fr = own_any && conf[own_idx][28];

  logic        cw_rej;
  logic [31:0] cw_val;
  assign cw_rej = (reg_wdata[27] | reg_wdata[28]) && own_any && own_idx != CW'(a_ch);
  assign cw_val = cw_rej ? (reg_wdata & ~32'h1800_0000) : reg_wdata;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      if (!en[c])
        ready[c] = 1'b0;
      else if (rxonly[c])
        ready[c] = armed[c] && ((fr && own_idx == CW'(c)) ? rf_cnt != (FAW+1)'(FD) : !rxf[c]);
      else
        ready[c] = (fw && own_idx == CW'(c)) ? tf_cnt != '0 : txfull[c];
    end
    sel = '0;
    for (int c = NCH-1; c >= 0; c--)
      if (ready[c]) sel = CW'(c);
  end
  assign start  = !busy && |ready;
  assign txword = (fw && own_idx == sel) ? tfifo[tf_rp] : txbuf[sel];

  logic tf_push, tf_pop, rf_push, rf_pop;
  assign tf_push = reg_we && a_chan && a_reg == 2'd2 && fw && CW'(a_ch) == own_idx
                   && !rxonly[own_idx] && tf_cnt != (FAW+1)'(FD);
  assign tf_pop  = start && fw && sel == own_idx && !rxonly[sel];
  assign rf_push = done && fr && ch == own_idx && mode_q != 2'b10 && rf_cnt != (FAW+1)'(FD);
  assign rf_pop  = reg_re && a_chan && a_reg == 2'd3 && fr && CW'(a_ch) == own_idx && rf_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tf_rp <= '0; tf_wp <= '0; tf_cnt <= '0;
      rf_rp <= '0; rf_wp <= '0; rf_cnt <= '0;
    end else begin
      if (tf_push) begin tfifo[tf_wp] <= reg_wdata; tf_wp <= tf_wp + 1'b1; end
      if (tf_pop)  tf_rp <= tf_rp + 1'b1;
      tf_cnt <= tf_cnt + (FAW+1)'(tf_push) - (FAW+1)'(tf_pop);
      if (rf_push) begin rfifo[rf_wp] <= rxsh; rf_wp <= rf_wp + 1'b1; end
      if (rf_pop)  rf_rp <= rf_rp + 1'b1;
      rf_cnt <= rf_cnt + (FAW+1)'(rf_push) - (FAW+1)'(rf_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0; txfull <= '0; armed <= '0; txe <= '0; rxf <= '0; err <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        conf[c] <= '0; txbuf[c] <= '0; rxbuf[c] <= '0;
      end
    end else begin
      if (reg_we && reg_addr == ST_ADDR && reg_wdata[2*NCH]) err <= 1'b0;
      if (reg_we && a_chan && a_reg == 2'd0 && cw_rej) err <= 1'b1;
      for (int c = 0; c < NCH; c++) begin
        if (reg_we && reg_addr == ST_ADDR) begin
          if (reg_wdata[2*c])   txe[c] <= 1'b0;
          if (reg_wdata[2*c+1]) rxf[c] <= 1'b0;
        end
        if (start && sel == CW'(c)) begin
          txe[c] <= 1'b1;
          txfull[c] <= 1'b0;
        end
        if (done && ch == CW'(c) && mode_q != 2'b10) begin
          rxf[c] <= 1'b1;
          if (!(fr && own_idx == CW'(c))) rxbuf[c] <= rxsh;
        end
        if (reg_we && a_chan && CW'(a_ch) == CW'(c)) begin
          case (a_reg)
            2'd0: conf[c] <= cw_val;
            2'd1: begin
              en[c] <= reg_wdata[0];
              if (!reg_wdata[0]) armed[c] <= 1'b0;
            end
            2'd2: begin
              if (rxonly[c]) armed[c] <= 1'b1;
              else if (!(fw && own_idx == CW'(c))) begin
                txbuf[c]  <= reg_wdata;
                txfull[c] <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign tick = dcnt == (HALF_LOG+1)'(HALF-1);
  assign done = busy && tick && ecnt == {nbits, 1'b0};
  assign kn   = ecnt + 7'd1;
  assign smp  = kn[0] ^ cpha_q;
  assign shf  = !smp && !(cpha_q && kn == 7'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ch <= '0; cur_ch <= '0; nbits <= 6'd4; ecnt <= '0; dcnt <= '0;
      sclk_t <= 1'b0; cpha_q <= 1'b0; cpol_q <= 1'b0; mode_q <= 2'b00;
      shreg <= '0; rxsh <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      ch     <= sel;
      cur_ch <= sel;
      nbits  <= wl_of(conf[sel]);
      cpha_q <= conf[sel][0];
      cpol_q <= conf[sel][1];
      mode_q <= conf[sel][13:12];
      ecnt   <= '0;
      dcnt   <= '0;
      sclk_t <= 1'b0;
      rxsh   <= '0;
      shreg  <= rxonly[sel] ? 32'd0 : txword << (6'd32 - wl_of(conf[sel]));
    end else if (busy) begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (tick) begin
        if (ecnt == {nbits, 1'b0}) busy <= 1'b0;
        else begin
          ecnt   <= kn;
          sclk_t <= ~sclk_t;
          if (smp) rxsh  <= {rxsh[30:0], miso_i};
          if (shf) shreg <= {shreg[30:0], 1'b0};
        end
      end
    end
  end

  assign sclk_o = busy ? (cpol_q ^ sclk_t) : conf[cur_ch][1];
  assign mosi_o = busy & shreg[31];

  logic [NCH-1:0] idle_lvl;
  always_comb
    for (int c = 0; c < NCH; c++) begin
      idle_lvl[c] = conf[c][6];
      cs_o[c]     = (busy && ch == CW'(c)) ? ~conf[c][6] : conf[c][6];
    end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ST_ADDR) begin
      for (int c = 0; c < NCH; c++) begin
        reg_rdata[2*c]   = txe[c];
        reg_rdata[2*c+1] = rxf[c];
      end
      reg_rdata[2*NCH] = err;
    end else if (a_chan) begin
      case (a_reg)
        2'd0: reg_rdata = conf[CW'(a_ch)];
        2'd1: reg_rdata = {31'd0, en[CW'(a_ch)]};
        2'd2: reg_rdata = txbuf[CW'(a_ch)];
        default: reg_rdata = (fr && own_idx == CW'(a_ch)) ? rfifo[rf_rp] : rxbuf[CW'(a_ch)];
      endcase
    end
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(own) <= 1);                                              // R9
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o ^ idle_lvl));                                         // R4
  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ecnt <= {nbits, 1'b0});                                    // R1
  AST_RXF_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q != 2'b10) |=> rxf[ch]);                             // R6
  AST_TXQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tf_cnt <= (FAW+1)'(FD) && rf_cnt <= (FAW+1)'(FD));                  // R10
endmodule

// File: tb/sim_spi_mc_master.sv
module sim_spi_mc_master;
  localparam int NCH = 2;
  localparam int AW  = $clog2(4*NCH+1);
  localparam logic [AW-1:0] ST = AW'(4*NCH);

  logic clk = 0, rst_n = 0, reg_we = 0, reg_re = 0, miso = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, mosi;
  logic [NCH-1:0] cs;

  spi_mc_master #(.NCH(NCH), .HALF_LOG(1), .FD(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_o(cs));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int bN[NCH], bpha[NCH], bpol[NCH], bcsp[NCH];
  int tch = 0, words = 0, edges = 0, nsam = 0, other_bad = 0;
  logic act = 0, pact = 0, psclk = 0;
  logic [31:0] rxw = 0, slv = 0;
  logic [31:0] cap [16];
  int capedg [16];

  function automatic int nb(input int f);
    return (f < 3) ? 4 : f + 1;
  endfunction
  function automatic logic [31:0] msk(input int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
  endfunction
  function automatic logic [31:0] pat(input int k);
    return 32'hA5C3_96E1 ^ (32'(k) * 32'h9E37_79B9);
  endfunction

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    for (int c = 0; c < NCH; c++)
      if (c != tch && cs[c] !== 1'(bcsp[c])) other_bad++;
    act = cs[tch] === ~1'(bcsp[tch]);
    if (act && !pact) begin
      edges = 0; nsam = 0; rxw = 0; slv = pat(words);
      miso = slv[bN[tch]-1];
    end else if (act && sclk !== psclk) begin
      edges++;
      if ((edges % 2 == 1) == (bpha[tch] == 0)) begin
        rxw = {rxw[30:0], mosi};
        nsam++;
        if (nsam < bN[tch]) miso = slv[bN[tch]-1-nsam];
      end
    end else if (!act && pact) begin
      cap[words % 16] = rxw;
      capedg[words % 16] = edges;
      words++;
    end
    pact = act; psclk = sclk;
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    if (a < 4*NCH && a % 4 == 0) begin
      bN[a/4] = nb(int'(d[11:7])); bpha[a/4] = d[0]; bpol[a/4] = d[1]; bcsp[a/4] = d[6];
    end
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_re = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 0;
  endtask

  task automatic wait_words(input int target, input string r);
    int t = 0;
    while (words < target && t < 5000) begin @(negedge clk); t++; end
    chk({r, " word completed"}, 32'(words >= target), 32'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int wd;
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, tx;
    int w0, f, n, c;
    void'($urandom(32'd4711));
    for (int i = 0; i < NCH; i++) begin bN[i] = 4; bpha[i] = 0; bpol[i] = 0; bcsp[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(ST, d);            chk("R6 reset status", d, 32'd0);
    chk("R4 reset cs", 32'(cs), 32'd0);
    chk("R2 reset sclk", 32'(sclk), 32'd0);

    wr(0, 32'd7 << 7); wr(1, 1); w0 = words; idle(100);
    chk("R8 no start without tx write", 32'(words), 32'(w0));

    for (int it = 0; it < 24; it++) begin
      c = $urandom % 2; f = $urandom % 32; n = nb(f);
      tch = c;
      wr(4*c, (32'(f) << 7) | (32'($urandom % 2) << 6) | (32'($urandom % 2) << 1) | 32'($urandom % 2));
      wr(4*(1-c) + 1, 0); wr(4*c + 1, 1); wr(ST, 32'hF);
      tx = $urandom; w0 = words;
      wr(4*c + 2, tx);
      wait_words(w0 + 1, "R1");
      idle(2);
      chk("R1 mosi word", cap[w0 % 16], tx & msk(n));
      chk("R3 clock edge count", 32'(capedg[w0 % 16]), 32'(2*n));
      rd(4*c + 3, d);     chk("R3 received word", d, pat(w0) & msk(n));
      rd(ST, d);          chk("R6 flags set", d & (32'h3 << 2*c), 32'h3 << 2*c);
      chk("R2 sclk idle level", 32'(sclk), 32'(bpol[c]));
      chk("R4 idle cs level", 32'(cs[c]), 32'(bcsp[c]));
    end
    chk("R4 other chip selects idle", 32'(other_bad), 32'd0);

    tch = 1;
    wr(4, 32'd5 << 7); wr(5, 0); wr(8, 0); wr(9, 0); wr(ST, 32'hF);
    wr(6, 32'h2C); w0 = words; idle(100);
    chk("R5 disabled channel silent", 32'(words), 32'(w0));
    wr(5, 1); wait_words(w0 + 1, "R5");
    chk("R5 pending data sent after enable", cap[w0 % 16], 32'h2C);

    wr(ST, 32'hF);
    wr(4, (32'd7 << 7) | (32'd2 << 12)); w0 = words;
    wr(6, 32'h5A); wait_words(w0 + 1, "R7"); idle(2);
    rd(ST, d);  chk("R7 tx-only no receive-full", d[3:2], 32'h1);

    wr(ST, 32'hF);
    wr(4, (32'd7 << 7) | (32'd1 << 12)); w0 = words;
    wr(6, 32'hFF); wait_words(w0 + 1, "R7"); idle(60);
    chk("R7 rx-only mosi low", cap[w0 % 16], 32'd0);
    chk("R7 rx-only waits for space", 32'(words), 32'(w0 + 1));
    wr(ST, 32'h4); idle(2);
    rd(ST, d);  chk("R6 write-1 clears only its bit", d[3:2], 32'h2);
    wr(ST, 32'h8); wait_words(w0 + 2, "R7");
    wr(5, 0); idle(40);
    rd(4*1 + 3, d); chk("R7 rx-only second word", d, pat(w0 + 1) & 32'hFF);

    wr(0, (32'd7 << 7) | (32'd1 << 27));
    wr(4, (32'd7 << 7) | (32'd1 << 28));
    rd(4, d);   chk("R9 second owner refused", d[28:27], 32'd0);
    rd(ST, d);  chk("R9 error flag", d[4], 32'd1);
    wr(ST, 32'h10);
    rd(ST, d);  chk("R9 error clears", d[4], 32'd0);

    tch = 0;
    wr(0, (32'd7 << 7) | (32'd3 << 27)); wr(1, 1); w0 = words;
    wr(2, 32'h11); wr(2, 32'h22); wr(2, 32'h33);
    wait_words(w0 + 3, "R10"); idle(4);
    for (int k = 0; k < 3; k++) begin
      chk("R10 fifo tx order", cap[(w0 + k) % 16], 32'(8'h11 * (k + 1)));
      rd(3, d);  chk("R10 fifo rx order", d, pat(w0 + k) & 32'hFF);
    end
    wr(0, 32'd7 << 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule